// File: doc/BRIEF.md
# Prioritized Paired-Channel Conversion Scheduler

This block shares one conversion engine among three sampling pairs, numbered 0, 1 and 2 (A, B, C). Each pair requests a conversion by driving its active-low hold line from high to low. The falling edge is seen on the falling clock edge. An accepted request is held in a per-pair pending mask until the engine is free. When the engine is free, the lowest-numbered pending pair starts on the next rising edge. Each conversion produces one result for channel X0 and one for channel X1. Both results are taken from the external converter data buses.

A conversion takes a fixed number of clocks. While it runs, the active-low busy output stays low. At the latch point, busy returns high and a one-cycle write strobe is issued, carrying the pair index and both results. A pair that is pending or converting takes no notice of further hold pulses until its results are latched. An asynchronous active-low reset drops the running conversion and every queued one.

Top module: `pair_conv_sched`

## Requirements
- R1: While reset is low and just after it, `busy_n` is 1, `wr_stb` is 0 and `hold_state` is 0.
- R2: A high-to-low transition on `hold_n[i]` is seen at a falling clock edge. When the engine is idle, conversion of pair i starts at the next rising edge: `busy_n` goes low and `conv_pair` equals i.
- R3: Pairs whose falls are seen at the same falling edge are converted in ascending index order: 0, then 1, then 2.
- R4: A request that arrives while the engine is busy is queued. Each following start comes exactly 16 rising edges after the previous one. When several pairs are queued, the lowest index is granted first.
- R5: A hold fall for a pair that is pending or converting is ignored. A hold line that stays low never starts a second conversion.
- R6: `busy_n` stays low for exactly 13 cycles per conversion. It rises in the same cycle that `wr_stb` is high.
- R7: `wr_stb` is high for a single cycle, 13 rising edges after the start. In that cycle, `wr_pair` is the converted pair, and `wr_x0`/`wr_x1` hold the `adc_x0`/`adc_x1` values sampled at that edge.
- R8: Asserting `rst_n` low cancels the running conversion and all queued ones. No strobe follows. A hold line kept low through reset starts nothing afterwards.
- R9: Bit i of `hold_state` is 1 while pair i is pending or converting, and clears at the latch edge of its conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; holds are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 3 | Active-low hold request per pair (bit 0 = A) |
| adc_x0 | input | 12 | Converter result for channel X0 |
| adc_x1 | input | 12 | Converter result for channel X1 |
| busy_n | output | 1 | Low while a conversion runs |
| conv_pair | output | 2 | Index of the pair being converted |
| hold_state | output | 3 | Pairs currently pending or converting |
| wr_stb | output | 1 | One-cycle write strobe at the latch point |
| wr_pair | output | 2 | Pair index for the strobe |
| wr_x0 | output | 12 | Latched X0 result |
| wr_x1 | output | 12 | Latched X1 result |

## Verification
The assertions check several rules on every cycle:
- the busy low time never exceeds the latch count;
- busy rises only together with a one-cycle strobe;
- two starts are never closer than the conversion length;
- the pair being converted is always marked as held.

Other behaviour only the bench's scenarios can show. These are the grant order for every combination of simultaneous requests, and the order among requests queued at different times. They also cover the exact start cycles, the data captured at the strobe edge, and whether repeated pulses are dropped or re-accepted around the latch. Cancellation by reset is covered the same way.

// File: rtl/pair_conv_sched.sv
module pair_conv_sched #(
  parameter int DW        = 12,
  parameter int NPAIR     = 3,
  parameter int CONV_CYC  = 16,
  parameter int LATCH_CYC = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPAIR-1:0]         hold_n,
  input  logic [DW-1:0]            adc_x0,
  input  logic [DW-1:0]            adc_x1,
  output logic                     busy_n,
  output logic [$clog2(NPAIR)-1:0] conv_pair,
  output logic [NPAIR-1:0]         hold_state,
  output logic                     wr_stb,
  output logic [$clog2(NPAIR)-1:0] wr_pair,
  output logic [DW-1:0]            wr_x0,
  output logic [DW-1:0]            wr_x1
);
  localparam int PW = $clog2(NPAIR);
  localparam int CW = $clog2(CONV_CYC);

  logic [NPAIR-1:0] hs, req, pend, cand, cur_oh;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    cur, gidx;
  logic             run, gany, can_go, latch;

  // hold lines sampled on the falling edge; a fall becomes a one-period request
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      hs  <= '0;
      req <= '0;
    end else begin
      hs  <= hold_n;
      req <= hs & ~hold_n;
    end

  assign cur_oh     = busy_n ? '0 : (NPAIR'(1) << cur);
  assign hold_state = pend | cur_oh;
  assign cand       = pend | (req & ~hold_state);
  assign can_go     = !run || (cnt == CW'(CONV_CYC - 1));
  assign latch      = run && (cnt == CW'(LATCH_CYC - 1));
  assign conv_pair  = cur;

  always_comb begin
    gidx = '0;
    gany = 1'b0;
    for (int i = NPAIR - 1; i >= 0; i--)
      if (cand[i]) begin
        gidx = PW'(i);
        gany = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      cur     <= '0;
      pend    <= '0;
      busy_n  <= 1'b1;
      wr_stb  <= 1'b0;
      wr_pair <= '0;
      wr_x0   <= '0;
      wr_x1   <= '0;
    end else begin
      wr_stb <= latch;
      if (latch) begin
        busy_n  <= 1'b1;
        wr_pair <= cur;
        wr_x0   <= adc_x0;
        wr_x1   <= adc_x1;
      end
      if (can_go && gany) begin
        run    <= 1'b1;
        cnt    <= '0;
        cur    <= gidx;
        busy_n <= 1'b0;
        pend   <= cand & ~(NPAIR'(1) << gidx);
      end else begin
        pend <= cand;
        if (run) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CONV_CYC - 1)) run <= 1'b0;
        end
      end
    end
endmodule

// File: rtl/pair_conv_sched_chk.sv
module pair_conv_sched_chk #(
  parameter int NPAIR     = 3,
  parameter int CONV_CYC  = 16,
  parameter int LATCH_CYC = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy_n,
  input logic [$clog2(NPAIR)-1:0] conv_pair,
  input logic [NPAIR-1:0]         hold_state,
  input logic                     wr_stb
);
  logic [15:0] lowc, sc;
  logic        prev_b;
  wire         fall = prev_b && !busy_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lowc   <= '0;
      sc     <= 16'(CONV_CYC);
      prev_b <= 1'b1;
    end else begin
      lowc   <= busy_n ? '0 : lowc + 1'b1;
      prev_b <= busy_n;
      if (fall) sc <= '0;
      else if (sc < 16'(CONV_CYC)) sc <= sc + 1'b1;
    end

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> lowc < 16'(LATCH_CYC));
  a_r6_rise_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> wr_stb);
  a_r7_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r7_stb_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> busy_n && $past(!busy_n));
  a_r9_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> hold_state[conv_pair]);
  a_r4_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> sc >= 16'(CONV_CYC - 1));
endmodule

bind pair_conv_sched pair_conv_sched_chk #(
  .NPAIR(NPAIR), .CONV_CYC(CONV_CYC), .LATCH_CYC(LATCH_CYC)
) chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .conv_pair(conv_pair),
  .hold_state(hold_state), .wr_stb(wr_stb)
);

// File: tb/pair_conv_sched_test.sv
module pair_conv_sched_test;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  hold_n = 3'b111;
  logic [11:0] adc_x0 = '0, adc_x1 = '0;
  logic        busy_n, wr_stb;
  logic [1:0]  conv_pair, wr_pair;
  logic [2:0]  hold_state;
  logic [11:0] wr_x0, wr_x1;

  pair_conv_sched uut (.*);

  always #5 clk = ~clk;

  int cyc = 0, total = 0, bad = 0, ns = 0, nstb = 0, ls = 0, lp = 0;
  int st_c[16], st_p[16];
  bit pb = 1, done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [11:0] f0(input int n); return 12'(n * 37 + 5); endfunction
  function automatic logic [11:0] f1(input int n); return 12'(n * 91 + 2000); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pb && !busy_n) begin
        if (ns < 16) begin st_c[ns] = cyc; st_p[ns] = int'(conv_pair); end
        ns++; ls = cyc; lp = int'(conv_pair);
      end
      if (!pb && busy_n) chk(cyc - ls == 13, "R6 busy low length", cyc - ls, 13);
      if (wr_stb) begin
        nstb++;
        chk(cyc - ls == 13, "R7 strobe timing", cyc - ls, 13);
        chk(int'(wr_pair) == lp, "R7 strobe pair", int'(wr_pair), lp);
        chk(wr_x0 == f0(cyc - 1), "R7 x0 data", int'(wr_x0), int'(f0(cyc - 1)));
        chk(wr_x1 == f1(cyc - 1), "R7 x1 data", int'(wr_x1), int'(f1(cyc - 1)));
      end
    end
    pb = busy_n;
    adc_x0 = f0(cyc);
    adc_x1 = f1(cyc);
  end

  task automatic goto(input int n);
    while (cyc < n) @(posedge clk);
    #2;
  endtask

  task automatic sweep(input logic [2:0] m);
    int c0, k;
    ns = 0; nstb = 0;
    @(posedge clk); #2;
    c0 = cyc;
    hold_n = ~m;
    goto(c0 + 2);
    hold_n = 3'b111;
    goto(c0 + 60);
    k = 0;
    for (int i = 0; i < 3; i++)
      if (m[i]) begin
        chk(st_p[k] == i, "R3 grant order", st_p[k], i);
        chk(st_c[k] == c0 + 1 + 16 * k, k == 0 ? "R2 start cycle" : "R4 queued start",
            st_c[k] - c0, 1 + 16 * k);
        k++;
      end
    chk(ns == k, "R3 start count", ns, k);
    chk(nstb == k, "R7 strobe count", nstb, k);
  endtask

  initial begin
    int c0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R1 reset busy", busy_n, 1);
    chk(wr_stb == 1'b0, "R1 reset strobe", wr_stb, 0);
    chk(hold_state == 3'b000, "R1 reset held", hold_state, 0);
    goto(3);
    rst_n = 1;
    goto(6);
    chk(busy_n == 1'b1 && hold_state == 0, "R1 after reset", busy_n, 1);

    for (int m = 1; m < 8; m++) sweep(3'(m));

    // R4: staggered arrivals, 1 first, then 2, then 0
    ns = 0; nstb = 0;
    @(posedge clk); #2; c0 = cyc;
    hold_n = 3'b101;
    goto(c0 + 3); hold_n = 3'b001;
    goto(c0 + 5); hold_n = 3'b000;
    goto(c0 + 7); hold_n = 3'b111;
    goto(c0 + 60);
    chk(ns == 3, "R4 count", ns, 3);
    chk(st_p[0] == 1 && st_c[0] == c0 + 1, "R4 first", st_p[0], 1);
    chk(st_p[1] == 0 && st_c[1] == c0 + 17, "R4 second lowest", st_p[1], 0);
    chk(st_p[2] == 2 && st_c[2] == c0 + 33, "R4 third", st_p[2], 2);

    // R5 and R9: repeated pulses on pair 0
    ns = 0; nstb = 0;
    @(posedge clk); #2; c0 = cyc;
    hold_n = 3'b110;
    goto(c0 + 2); hold_n = 3'b111;
    goto(c0 + 4); hold_n = 3'b110;
    @(negedge clk);
    goto(c0 + 5);
    @(negedge clk);
    chk(hold_state == 3'b001, "R9 held while converting", hold_state, 1);
    goto(c0 + 6); hold_n = 3'b111;
    goto(c0 + 14); hold_n = 3'b110;
    @(negedge clk);
    chk(hold_state == 3'b000, "R9 cleared at latch", hold_state, 0);
    goto(c0 + 15);
    @(negedge clk);
    chk(hold_state == 3'b001, "R5 re-accepted after latch", hold_state, 1);
    goto(c0 + 16); hold_n = 3'b111;
    goto(c0 + 60);
    chk(ns == 2, "R5 ignored pulse", ns, 2);
    chk(st_c[1] == c0 + 17, "R5 second start", st_c[1] - c0, 17);

    // R5: held low does not repeat
    ns = 0;
    @(posedge clk); #2; c0 = cyc;
    hold_n = 3'b011;
    goto(c0 + 70);
    chk(ns == 1, "R5 steady low", ns, 1);
    hold_n = 3'b111;
    goto(c0 + 75);

    // R8: reset cancels everything
    ns = 0; nstb = 0;
    @(posedge clk); #2; c0 = cyc;
    hold_n = 3'b000;
    goto(c0 + 5); rst_n = 0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R8 busy cleared", busy_n, 1);
    chk(hold_state == 3'b000, "R8 queue cleared", hold_state, 0);
    goto(c0 + 7); rst_n = 1;
    goto(c0 + 60);
    chk(nstb == 0, "R8 no strobe", nstb, 0);
    chk(ns == 1, "R8 no restart", ns, 1);
    hold_n = 3'b111;
    goto(c0 + 63);
    sweep(3'b101);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule